// File: doc/BRIEF.md
# Pulse-Width Modulator with Deferred or Immediate Duty Update

This block produces one pulse-width-modulated output. A prescaler divides the system clock by 1, 2, 4 or 16 to make a count tick. Two down-counters run on that tick. One measures the period, and the other measures the high time at the start of each period.

Software loads a period count, a duty count and a configuration word through a one-cycle register write port. It then pulses `start` to begin generation or `stop` to end it. A configuration bit selects when a new duty count takes effect:

- Held mode: the new duty is kept back until the running period ends and the counters reload.
- Immediate mode: the new duty reshapes the period that is already in progress.

The output can never stay high for a whole period. Every period keeps at least one low count. A one-cycle `period_end` flag marks every reload, so the host can count periods.

Top module: `pwm_gen`

## Requirements
- R1: The config write selects the tick divider in bits [1:0]: 0 gives /1, 1 gives /2, 2 gives /4, 3 gives /16. Each count then lasts that many clock cycles.
- R2: With period P ≥ 2 and duty D < P, each period lasts P counts. The output is high for the first D counts and low for the remaining P−D counts.
- R3: A period value of 0 or 1 behaves as a period of 2.
- R4: A duty of 0 keeps the output low for the whole period.
- R5: A duty equal to or above the effective period gives P−1 high counts and one low count. The output is never high for a full period.
- R6: With config bit 2 set (held mode), a duty write does not change the current period. It applies from the next reload.
- R7: With config bit 2 clear (immediate mode), a duty write takes effect at the edge that captures it. From that edge on, the output follows the new duty as if it had been in force since the period began.
- R8: A period write never changes the running period. It applies from the next reload, in both modes.
- R9: A `start` pulse reloads the counters at the edge that captures it, also while the block is running. The output and `period_end` reflect the new period in the next cycle.
- R10: `stop` forces the output low from the next cycle and suppresses `period_end` until the next start. If `stop` and `start` arrive together, `stop` wins.
- R11: `period_end` is high for exactly one cycle at the start of every period.
- R12: After reset the block is stopped, with the output and `period_end` low. Register write selects are 0 for period, 1 for duty and 2 for config.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_sel | input | 2 | Register select: 0 period, 1 duty, 2 config |
| wr_data | input | CNT_W | Write data (config uses bits [2:0]) |
| start | input | 1 | Start or restart pulse |
| stop | input | 1 | Stop pulse; has priority over start |
| pwm_out | output | 1 | Modulated output |
| period_end | output | 1 | One-cycle flag in the first cycle of each period |

## Verification
The assertions assume the divider setting does not change while the output runs. They also assume `wr_sel` never holds the unused value 3 during a write. The bench honours both: it stops the block before every config write, and it only uses selects 0 to 2.

Mid-period duty and period writes are placed at a fixed cycle offset after a `period_end`. This makes the expected high count of the disturbed period follow directly from R6, R7 and R8.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_CONFIG = 2'd2
  } wr_sel_e;

  typedef enum logic [1:0] {
    DIV_1  = 2'd0,
    DIV_2  = 2'd1,
    DIV_4  = 2'd2,
    DIV_16 = 2'd3
  } presc_e;

  typedef struct packed {
    logic   upd_hold;  // 1: duty waits for reload, 0: duty applies at once
    presc_e div;
  } pwm_cfg_t;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
#(
  parameter int DIV_MAX = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   restart,
  input  presc_e sel,
  output logic   tick
);

  localparam int PW = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

  logic [PW-1:0] pcnt;

  // terminal value of the divider counter for each setting
  function automatic logic [PW-1:0] last_of(input presc_e s);
    case (s)
      DIV_1:   last_of = PW'(0);
      DIV_2:   last_of = PW'(1);
      DIV_4:   last_of = PW'(3);
      default: last_of = PW'(15);
    endcase
  endfunction

  assign tick = run && (pcnt == last_of(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pcnt <= '0;
    else if (restart || !run || tick) pcnt <= '0;
    else                              pcnt <= pcnt + PW'(1);
  end

endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output pwm_cfg_t         cfg,
  output logic [CNT_W-1:0] period_nx,
  output logic [CNT_W-1:0] duty_nx,
  output logic             duty_wr
);

  logic [CNT_W-1:0] period_sh;
  logic [CNT_W-1:0] duty_sh;
  logic             period_wr;
  logic             cfg_wr;

  assign period_wr = wr_en && (wr_sel == SEL_PERIOD);
  assign duty_wr   = wr_en && (wr_sel == SEL_DUTY);
  assign cfg_wr    = wr_en && (wr_sel == SEL_CONFIG);

  // next-state views so a reload in the write cycle sees the new value
  assign period_nx = period_wr ? wr_data : period_sh;
  assign duty_nx   = duty_wr   ? wr_data : duty_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_sh <= '0;
      duty_sh   <= '0;
      cfg       <= '{upd_hold: 1'b0, div: DIV_1};
    end else begin
      period_sh <= period_nx;
      duty_sh   <= duty_nx;
      if (cfg_wr) cfg <= '{upd_hold: wr_data[2], div: presc_e'(wr_data[1:0])};
    end
  end

endmodule

// File: rtl/pwm_counter_core.sv
module pwm_counter_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic             upd_hold,
  input  logic [CNT_W-1:0] period_nx,
  input  logic [CNT_W-1:0] duty_nx,
  input  logic             duty_wr,
  output logic             running,
  output logic [CNT_W-1:0] prd_cnt,
  output logic [CNT_W-1:0] hi_cnt,
  output logic             reload_ev,
  output logic             period_end,
  output logic             pwm_out
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] prd_act;
  logic [CNT_W-1:0] p_eff;
  logic [CNT_W-1:0] d_eff;
  logic [CNT_W-1:0] prd_step;
  logic [CNT_W-1:0] hi_live;
  logic             load;

  // shortest usable period is two counts
  function automatic logic [CNT_W-1:0] eff_period(input logic [CNT_W-1:0] p);
    eff_period = (p < TWO) ? TWO : p;
  endfunction

  // duty is capped one count below the period so a low phase remains
  function automatic logic [CNT_W-1:0] eff_duty(input logic [CNT_W-1:0] d,
                                                input logic [CNT_W-1:0] p);
    eff_duty = (d >= p) ? (p - ONE) : d;
  endfunction

  // high counts still owed when e counts of the period have gone by
  function automatic logic [CNT_W-1:0] remain_high(input logic [CNT_W-1:0] d,
                                                   input logic [CNT_W-1:0] e);
    remain_high = (d > e) ? (d - e) : '0;
  endfunction

  assign p_eff     = eff_period(period_nx);
  assign d_eff     = eff_duty(duty_nx, p_eff);
  assign reload_ev = running && tick && (prd_cnt == '0) && !stop_ev;
  assign load      = (start_ev && !stop_ev) || reload_ev;
  assign prd_step  = tick ? (prd_cnt - ONE) : prd_cnt;
  assign hi_live   = remain_high(eff_duty(duty_nx, prd_act), prd_act - ONE - prd_step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      prd_cnt    <= '0;
      hi_cnt     <= '0;
      prd_act    <= TWO;
      period_end <= 1'b0;
    end else begin
      period_end <= load;
      if (stop_ev) begin
        running <= 1'b0;
        prd_cnt <= '0;
        hi_cnt  <= '0;
      end else if (load) begin
        running <= 1'b1;
        prd_act <= p_eff;
        prd_cnt <= p_eff - ONE;
        hi_cnt  <= d_eff;
      end else if (running) begin
        prd_cnt <= prd_step;
        if (duty_wr && !upd_hold)          hi_cnt <= hi_live;
        else if (tick && (hi_cnt != '0))   hi_cnt <= hi_cnt - ONE;
      end
    end
  end

  assign pwm_out = running && (hi_cnt != '0);

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int DIV_MAX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             start,
  input  logic             stop,
  output logic             pwm_out,
  output logic             period_end
);

  pwm_cfg_t         cfg;
  logic [CNT_W-1:0] period_nx;
  logic [CNT_W-1:0] duty_nx;
  logic             duty_wr;
  logic             tick;
  logic             running;
  logic [CNT_W-1:0] prd_cnt;
  logic [CNT_W-1:0] hi_cnt;
  logic             reload_ev;
  logic             start_ev;
  logic             presc_nonunit;

  assign start_ev      = start && !stop;
  assign presc_nonunit = (cfg.div != DIV_1);

  pwm_shadow_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .cfg       (cfg),
    .period_nx (period_nx),
    .duty_nx   (duty_nx),
    .duty_wr   (duty_wr)
  );

  pwm_prescaler #(.DIV_MAX(DIV_MAX)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .restart (start_ev),
    .sel     (cfg.div),
    .tick    (tick)
  );

  pwm_counter_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .start_ev   (start_ev),
    .stop_ev    (stop),
    .upd_hold   (cfg.upd_hold),
    .period_nx  (period_nx),
    .duty_nx    (duty_nx),
    .duty_wr    (duty_wr),
    .running    (running),
    .prd_cnt    (prd_cnt),
    .hi_cnt     (hi_cnt),
    .reload_ev  (reload_ev),
    .period_end (period_end),
    .pwm_out    (pwm_out)
  );

endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             pwm_out,
  input logic             period_end,
  input logic             tick,
  input logic             reload_ev,
  input logic             running,
  input logic [CNT_W-1:0] prd_cnt,
  input logic [CNT_W-1:0] hi_cnt,
  input logic             hold_mode,
  input logic             presc_nonunit
);

  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!pwm_out && !period_end)); // R10

  AST_START_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> (period_end && running)); // R9

  AST_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (hi_cnt <= prd_cnt)); // R5

  AST_PRD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && (prd_cnt != '0) && !start && !stop)
      |=> (prd_cnt == $past(prd_cnt) - CNT_W'(1))); // R2

  AST_RELOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    reload_ev |=> period_end); // R11

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_nonunit && tick && !wr_en && !start) |=> !tick); // R1

  AST_HELD_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (running && hold_mode && wr_en && (wr_sel == 2'd1) && !tick && !start && !stop)
      |=> $stable(hi_cnt)); // R6

endmodule

bind pwm_gen pwm_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .stop          (stop),
  .wr_en         (wr_en),
  .wr_sel        (wr_sel),
  .pwm_out       (pwm_out),
  .period_end    (period_end),
  .tick          (tick),
  .reload_ev     (reload_ev),
  .running       (running),
  .prd_cnt       (prd_cnt),
  .hi_cnt        (hi_cnt),
  .hold_mode     (cfg.upd_hold),
  .presc_nonunit (presc_nonunit)
);

// File: tb/pwm_gen_test.sv
module pwm_gen_test;

  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [CW-1:0] wr_data = '0;
  logic          start = 1'b0;
  logic          stop = 1'b0;
  logic          pwm_out;
  logic          period_end;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_gen #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .stop(stop), .pwm_out(pwm_out), .period_end(period_end)
  );

  // columns: divider code, period, duty, expected high cycles, expected period cycles
  localparam int NV = 10;
  localparam int VEC [NV][5] = '{
    '{0, 10, 3,   3, 10},   // R2 R1 /1
    '{1,  8, 4,   8, 16},   // R1 /2
    '{2,  5, 1,   4, 20},   // R1 /4
    '{3,  3, 2,  32, 48},   // R1 /16
    '{0,  6, 0,   0,  6},   // R4 zero duty
    '{0,  6, 6,   5,  6},   // R5 duty equals period
    '{0,  6, 100, 5,  6},   // R5 duty above period
    '{0,  1, 1,   1,  2},   // R3 period one
    '{0,  0, 5,   1,  2},   // R3 period zero
    '{0,  2, 1,   1,  2}    // R2 smallest period
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [CW-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // leaves the bench at the negedge of the first cycle after the start edge
  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  // called at the negedge of a period's first cycle; optional write at cycle 'at'
  task automatic measure(input int at, input logic [1:0] sel, input logic [CW-1:0] data,
                         output int hi, output int len);
    hi = 0; len = 0;
    do begin
      if (len == at) begin
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
      end else begin
        wr_en = 1'b0;
      end
      if (pwm_out) hi++;
      len++;
      @(negedge clk);
    end while (!period_end && len < 2000);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int cfgw, input int p, input int d);
    @(negedge clk);
    pulse_stop();
    write_reg(2'd2, CW'(cfgw));
    write_reg(2'd0, CW'(p));
    write_reg(2'd1, CW'(d));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi, len, cnt_hi, cnt_pe;

    // R12 reset state
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R12 reset pwm_out", pwm_out, 0);
    check(period_end == 1'b0, "R12 reset period_end", period_end, 0);
    rst_n = 1'b1;
    cnt_hi = 0; cnt_pe = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pwm_out) cnt_hi++;
      if (period_end) cnt_pe++;
    end
    check(cnt_hi == 0 && cnt_pe == 0, "R12 idle after reset", cnt_hi + cnt_pe, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][0], VEC[i][1], VEC[i][2]);
      pulse_start();
      check(period_end == 1'b1, "R9 period_end after start", period_end, 1);
      measure(-1, 2'd0, '0, hi, len);
      check(hi == VEC[i][3], $sformatf("R2 vec%0d high cycles", i), hi, VEC[i][3]);
      check(len == VEC[i][4], $sformatf("R11 vec%0d period cycles", i), len, VEC[i][4]);
    end

    // R6 held mode: duty 2 -> 7 at cycle 5
    setup(4, 10, 2);
    pulse_start();
    measure(5, 2'd1, CW'(7), hi, len);
    check(hi == 2, "R6 held: current period high", hi, 2);
    check(len == 10, "R6 held: current period length", len, 10);
    measure(-1, 2'd0, '0, hi, len);
    check(hi == 7, "R6 held: next period high", hi, 7);

    // R7 immediate mode: duty 2 -> 7 at cycle 5; cycle 6 turns high
    setup(0, 10, 2);
    pulse_start();
    measure(5, 2'd1, CW'(7), hi, len);
    check(hi == 3, "R7 immediate: current period high", hi, 3);
    check(len == 10, "R7 immediate: current period length", len, 10);
    measure(-1, 2'd0, '0, hi, len);
    check(hi == 7, "R7 immediate: next period high", hi, 7);

    // R8 period write 10 -> 4 mid period; duty 7 then capped to 3
    measure(5, 2'd0, CW'(4), hi, len);
    check(len == 10, "R8 current period unchanged", len, 10);
    check(hi == 7, "R8 current high unchanged", hi, 7);
    measure(-1, 2'd0, '0, hi, len);
    check(len == 4, "R8 new period length", len, 4);
    check(hi == 3, "R8 new period high (R5 cap)", hi, 3);

    // R9 restart while running, 2 cycles into a period
    @(negedge clk);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(period_end == 1'b1, "R9 restart period_end", period_end, 1);
    check(pwm_out == 1'b1, "R9 restart output high", pwm_out, 1);
    measure(-1, 2'd0, '0, hi, len);
    check(len == 4, "R9 restarted period length", len, 4);

    // R10 stop during high phase
    check(pwm_out == 1'b1, "R10 high before stop", pwm_out, 1);
    pulse_stop();
    check(pwm_out == 1'b0, "R10 low after stop", pwm_out, 0);
    cnt_hi = 0; cnt_pe = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pwm_out) cnt_hi++;
      if (period_end) cnt_pe++;
    end
    check(cnt_hi == 0, "R10 output stays low", cnt_hi, 0);
    check(cnt_pe == 0, "R10 no period_end while stopped", cnt_pe, 0);

    // R10 stop wins over simultaneous start
    start = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    check(period_end == 1'b0, "R10 stop beats start: period_end", period_end, 0);
    check(pwm_out == 1'b0, "R10 stop beats start: output", pwm_out, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule